// File: doc/BRIEF.md
# Windowed Dual-Memory Access Router

This block sits between a processor bus and two memories: the main system RAM and a larger graphics RAM. The processor address space is cut into equal windows of 8 KB each. Every window has a small mode register and a page register. The mode register decides where reads in that window are served from. Separately, it decides where writes in that window land: main RAM, graphics RAM, or both at once. The page register picks which 8 KB page of graphics RAM is seen through the window.

After reset every window reads and writes main RAM, so the router has no effect until software programs it. The mode and page registers are themselves reached through a small, fixed range of bus addresses. Accesses in that range always go to the registers, whatever the mode of the window that holds the range.

All outputs are registered. Each access presented on one clock edge yields chip selects, write enables, addresses, write data and a read-data mux select on that same edge, and they hold for the cycle that follows.

Top module: `bank_router`

## Requirements
- R1: After reset every window has read source main and write target main, every page register is 0, and all chip selects and write enables are low.
- R2: A read outside the register range asserts exactly one chip select, with no write enable. The mode bit 0 of the window chooses it: 0 gives main RAM and `rd_sel`=0, 1 gives graphics RAM and `rd_sel`=1.
- R3: A write outside the register range follows mode bits 2:1 of the window. Code 00 or 11 writes main RAM only, 01 writes graphics RAM only, and 10 writes both memories in the same cycle. Every asserted write enable comes with its chip select.
- R4: The read source and the write target of a window are independent, so a window can read one memory and write the other.
- R5: `gfx_addr` equals {page register of the window, `cpu_addr[12:0]`}. The window is `cpu_addr[15:13]`. `main_addr` equals `cpu_addr`, and `mem_wdata` equals `cpu_wdata` of the same access.
- R6: There are 16 register bytes starting at `CFG_BASE` (default 0xDE00). The byte at offset 2w is the mode of window w, with bit 0 for read source and bits 2:1 for write target; upper bits read as 0. The byte at offset 2w+1 is the page of window w. A read there returns the value on `cfg_rdata` with `rd_sel`=2.
- R7: An access inside the register range asserts no memory chip select or write enable, even when the window that contains the range is mapped to graphics RAM.
- R8: A cycle with neither read nor write asserts no chip select or write enable.
- R9: A cycle with read and write both asserted is handled as a write only, with `rd_sel`=0.
- R10: A register write takes effect for the access in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read request this cycle |
| cpu_wr | input | 1 | Write request this cycle |
| cpu_wdata | input | 8 | Processor write data |
| main_cs | output | 1 | Main RAM chip select |
| main_we | output | 1 | Main RAM write enable |
| main_addr | output | 16 | Main RAM address |
| gfx_cs | output | 1 | Graphics RAM chip select |
| gfx_we | output | 1 | Graphics RAM write enable |
| gfx_addr | output | 21 | Graphics RAM address (page and offset) |
| mem_wdata | output | 8 | Write data for both memories |
| rd_sel | output | 2 | Read data source: 0 main, 1 graphics, 2 registers |
| cfg_rdata | output | 8 | Register read-back data |

## Verification
Every memory-side result and every register read-back is due on the first rising edge after the access is presented, because the decode feeds one output register stage. The bench changes inputs at the falling edge and samples one time unit after the next rising edge, so each check sees exactly the response to its own access. A register write is committed on its own edge, and the access in the following cycle is checked against the new setting. This shows that a mode or page change needs no extra wait.

// File: rtl/bank_router_pkg.sv
package bank_router_pkg;

  // Read data source select driven to the bus-side mux
  typedef enum logic [1:0] {
    RD_MAIN = 2'd0,
    RD_GFX  = 2'd1,
    RD_CFG  = 2'd2
  } rd_sel_e;

  // Write target code held in mode bits [2:1]
  typedef enum logic [1:0] {
    WT_MAIN     = 2'd0,
    WT_GFX      = 2'd1,
    WT_BOTH     = 2'd2,
    WT_MAIN_ALT = 2'd3
  } wr_tgt_e;

  localparam int MODE_W = 3;

  // Per-window mode: bit 0 read source, bits 2:1 write target
  typedef struct packed {
    wr_tgt_e wr_tgt;
    logic    rd_gfx;
  } win_mode_t;

endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
  import bank_router_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = 3,
  parameter int PAGE_W  = 8,
  parameter int DATA_W  = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               reg_we,
  input  logic [IDX_W-1:0]                   reg_idx,
  input  logic                               reg_sel_page,
  input  logic [DATA_W-1:0]                  reg_wdata,
  output win_mode_t [NUM_WIN-1:0]            mode_q,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]     page_q,
  output logic [DATA_W-1:0]                  reg_rdata
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[w] <= '0;
        page_q[w] <= '0;
      end else if (reg_we && reg_idx == IDX_W'(w)) begin
        if (reg_sel_page) page_q[w] <= reg_wdata[PAGE_W-1:0];
        else              mode_q[w] <= win_mode_t'(reg_wdata[MODE_W-1:0]);
      end
    end
  end

  always_comb begin
    if (reg_sel_page) reg_rdata = DATA_W'(page_q[reg_idx]);
    else              reg_rdata = DATA_W'(mode_q[reg_idx]);
  end

  // R6: register contents change only through a register write
  p_cfg_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> ($stable(page_q) && $stable(mode_q)));

endmodule

// File: rtl/bank_decode.sv
module bank_decode
  import bank_router_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_W    = 13,
  parameter int                PAGE_W   = 8,
  parameter int                WSEL_W   = 3,
  parameter int                NUM_WIN  = 8,
  parameter logic [ADDR_W-1:0] CFG_BASE = 16'hDE00
) (
  input  logic [ADDR_W-1:0]              cpu_addr,
  input  logic                           cpu_rd,
  input  logic                           cpu_wr,
  input  win_mode_t [NUM_WIN-1:0]        mode_q,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0] page_q,
  output logic                           in_cfg,
  output logic                           reg_we,
  output logic [WSEL_W-1:0]              reg_idx,
  output logic                           reg_sel_page,
  output logic                           nxt_main_cs,
  output logic                           nxt_main_we,
  output logic                           nxt_gfx_cs,
  output logic                           nxt_gfx_we,
  output logic [1:0]                     nxt_rd_sel,
  output logic [PAGE_W+WIN_W-1:0]        nxt_gfx_addr
);

  localparam int CFG_SPAN = 2 * NUM_WIN;

  logic [WSEL_W-1:0] win;
  logic [ADDR_W-1:0] cfg_off;
  win_mode_t         cur;

  assign win     = cpu_addr[ADDR_W-1:WIN_W];
  assign cfg_off = cpu_addr - CFG_BASE;
  assign in_cfg  = (cpu_addr >= CFG_BASE) && (cfg_off < ADDR_W'(CFG_SPAN));
  assign reg_idx      = cfg_off[WSEL_W:1];
  assign reg_sel_page = cfg_off[0];
  assign reg_we       = in_cfg && cpu_wr;
  assign cur          = mode_q[win];
  assign nxt_gfx_addr = {page_q[win], cpu_addr[WIN_W-1:0]};

  always_comb begin
    nxt_main_cs = 1'b0;
    nxt_main_we = 1'b0;
    nxt_gfx_cs  = 1'b0;
    nxt_gfx_we  = 1'b0;
    nxt_rd_sel  = RD_MAIN;
    if (in_cfg) begin
      if (cpu_rd && !cpu_wr) nxt_rd_sel = RD_CFG;
    end else if (cpu_wr) begin
      unique case (cur.wr_tgt)
        WT_GFX: begin
          nxt_gfx_cs = 1'b1;
          nxt_gfx_we = 1'b1;
        end
        WT_BOTH: begin
          nxt_main_cs = 1'b1;
          nxt_main_we = 1'b1;
          nxt_gfx_cs  = 1'b1;
          nxt_gfx_we  = 1'b1;
        end
        default: begin
          nxt_main_cs = 1'b1;
          nxt_main_we = 1'b1;
        end
      endcase
    end else if (cpu_rd) begin
      if (cur.rd_gfx) begin
        nxt_gfx_cs = 1'b1;
        nxt_rd_sel = RD_GFX;
      end else begin
        nxt_main_cs = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bank_router.sv
module bank_router
  import bank_router_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_W    = 13,
  parameter int                PAGE_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_BASE = 16'hDE00
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_rd,
  input  logic                    cpu_wr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    main_cs,
  output logic                    main_we,
  output logic [ADDR_W-1:0]       main_addr,
  output logic                    gfx_cs,
  output logic                    gfx_we,
  output logic [PAGE_W+WIN_W-1:0] gfx_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic [1:0]              rd_sel,
  output logic [DATA_W-1:0]       cfg_rdata
);

  localparam int WSEL_W  = ADDR_W - WIN_W;
  localparam int NUM_WIN = 1 << WSEL_W;
  localparam int GADDR_W = PAGE_W + WIN_W;

  win_mode_t [NUM_WIN-1:0]        mode_q;
  logic [NUM_WIN-1:0][PAGE_W-1:0] page_q;
  logic                           in_cfg, reg_we, reg_sel_page;
  logic [WSEL_W-1:0]              reg_idx;
  logic [DATA_W-1:0]              reg_rdata;
  logic                           nxt_main_cs, nxt_main_we, nxt_gfx_cs, nxt_gfx_we;
  logic [1:0]                     nxt_rd_sel;
  logic [GADDR_W-1:0]             nxt_gfx_addr;

  bank_cfg_regs #(
    .NUM_WIN (NUM_WIN),
    .IDX_W   (WSEL_W),
    .PAGE_W  (PAGE_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .reg_we       (reg_we),
    .reg_idx      (reg_idx),
    .reg_sel_page (reg_sel_page),
    .reg_wdata    (cpu_wdata),
    .mode_q       (mode_q),
    .page_q       (page_q),
    .reg_rdata    (reg_rdata)
  );

  bank_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_W    (WIN_W),
    .PAGE_W   (PAGE_W),
    .WSEL_W   (WSEL_W),
    .NUM_WIN  (NUM_WIN),
    .CFG_BASE (CFG_BASE)
  ) u_dec (
    .cpu_addr     (cpu_addr),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .mode_q       (mode_q),
    .page_q       (page_q),
    .in_cfg       (in_cfg),
    .reg_we       (reg_we),
    .reg_idx      (reg_idx),
    .reg_sel_page (reg_sel_page),
    .nxt_main_cs  (nxt_main_cs),
    .nxt_main_we  (nxt_main_we),
    .nxt_gfx_cs   (nxt_gfx_cs),
    .nxt_gfx_we   (nxt_gfx_we),
    .nxt_rd_sel   (nxt_rd_sel),
    .nxt_gfx_addr (nxt_gfx_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      main_cs   <= 1'b0;
      main_we   <= 1'b0;
      gfx_cs    <= 1'b0;
      gfx_we    <= 1'b0;
      rd_sel    <= RD_MAIN;
      main_addr <= '0;
      gfx_addr  <= '0;
      mem_wdata <= '0;
      cfg_rdata <= '0;
    end else begin
      main_cs   <= nxt_main_cs;
      main_we   <= nxt_main_we;
      gfx_cs    <= nxt_gfx_cs;
      gfx_we    <= nxt_gfx_we;
      rd_sel    <= nxt_rd_sel;
      main_addr <= cpu_addr;
      gfx_addr  <= nxt_gfx_addr;
      mem_wdata <= cpu_wdata;
      cfg_rdata <= reg_rdata;
    end
  end

  // R2: a plain memory read selects exactly one memory and writes nothing
  p_one_source_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && !in_cfg) |=>
      ($countones({main_cs, gfx_cs}) == 1 && !main_we && !gfx_we));

  // R3: a memory write reaches at least one memory
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !in_cfg) |=> (main_we || gfx_we));

  // R3: no write enable without its chip select
  p_we_has_cs_r3: assert property (@(posedge clk) disable iff (rst)
    (main_we || gfx_we) |-> ((!main_we || main_cs) && (!gfx_we || gfx_cs)));

  // R5: graphics offset and main address follow the bus address
  p_addr_follow_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd || cpu_wr) |=>
      (gfx_addr[WIN_W-1:0] == $past(cpu_addr[WIN_W-1:0]) && main_addr == $past(cpu_addr)));

  // R7: register accesses never touch memory
  p_cfg_no_mem_r7: assert property (@(posedge clk) disable iff (rst)
    (in_cfg && (cpu_rd || cpu_wr)) |=> (!main_cs && !gfx_cs));

  // R8: idle cycles select nothing
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |=> (!main_cs && !gfx_cs && !main_we && !gfx_we));

  // R9: read plus write is a write, not a read
  p_rw_is_write_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_wr) |=> (rd_sel == RD_MAIN));

endmodule

// File: tb/bank_router_tb.sv
module bank_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 15;

  typedef struct packed {
    logic [15:0] addr;
    logic        rd;
    logic        wr;
    logic        mcs;
    logic        mwe;
    logic        gcs;
    logic        gwe;
    logic [1:0]  rsel;
    logic [20:0] gaddr;
  } vec_t;

  // Window setup done before the table:
  // w0 read gfx/write main page 12, w1 read main/write gfx page 34,
  // w2 read gfx/write both page FF, w3 code 11 page 07, w6 gfx/both page 55
  localparam vec_t VECS [NVEC] = '{
    '{16'h0123, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 21'h024123},
    '{16'h1FFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 21'h025FFF},
    '{16'h2000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 21'h068000},
    '{16'h2ABC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 21'h068ABC},
    '{16'h4000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 21'h1FE000},
    '{16'h5FFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 21'h1FFFFF},
    '{16'h6001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 21'h00E001},
    '{16'h6001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 21'h00E001},
    '{16'h8000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 21'h000000},
    '{16'hE000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 21'h000000},
    '{16'h0123, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 21'h024123},
    '{16'h0123, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 21'h024123},
    '{16'hC000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 21'h0AA000},
    '{16'hDE10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 21'h0ABE10},
    '{16'hDDFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 21'h0ABDFF}
  };

  localparam string VTAG [NVEC] = '{
    "R2", "R4", "R4", "R3", "R5", "R3", "R3", "R2",
    "R1", "R1", "R8", "R9", "R5", "R6", "R6"
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata;
  logic        main_cs, main_we, gfx_cs, gfx_we;
  logic [15:0] main_addr;
  logic [20:0] gfx_addr;
  logic [7:0]  mem_wdata, cfg_rdata;
  logic [1:0]  rd_sel;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_router u_dut (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .main_cs   (main_cs),
    .main_we   (main_we),
    .main_addr (main_addr),
    .gfx_cs    (gfx_cs),
    .gfx_we    (gfx_we),
    .gfx_addr  (gfx_addr),
    .mem_wdata (mem_wdata),
    .rd_sel    (rd_sel),
    .cfg_rdata (cfg_rdata)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Present one access at the falling edge; return just after the next rising edge
  task automatic access(input logic [15:0] a, input logic r, input logic w,
                        input logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_rd    = r;
    cpu_wr    = w;
    cpu_wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    access(16'h0000, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic cfg_write(input int win, input bit page, input logic [7:0] d);
    access(16'hDE00 + 16'(2*win) + 16'(page), 1'b0, 1'b1, d);
  endtask

  task automatic check_strobes(input string tag, input logic mcs, input logic mwe,
                               input logic gcs, input logic gwe);
    check(tag, "strobes {mcs,mwe,gcs,gwe}", {main_cs, main_we, gfx_cs, gfx_we},
          {28'd0, mcs, mwe, gcs, gwe});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cpu_addr = '0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs idle while in reset
    check_strobes("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R1: default window reads and writes main
    access(16'h0040, 1'b1, 1'b0, 8'h00);
    check_strobes("R1", 1'b1, 1'b0, 1'b0, 1'b0);
    check("R1", "rd_sel default", 32'(rd_sel), 32'd0);
    access(16'h0040, 1'b0, 1'b1, 8'h3C);
    check_strobes("R1", 1'b1, 1'b1, 1'b0, 1'b0);
    check("R5", "mem_wdata", 32'(mem_wdata), 32'h3C);
    access(16'hDE01, 1'b1, 1'b0, 8'h00);
    check("R1", "page reset value", 32'(cfg_rdata), 32'd0);

    // Program windows
    cfg_write(0, 1'b0, 8'h01); cfg_write(0, 1'b1, 8'h12);
    cfg_write(1, 1'b0, 8'h02); cfg_write(1, 1'b1, 8'h34);
    cfg_write(2, 1'b0, 8'h05); cfg_write(2, 1'b1, 8'hFF);
    cfg_write(3, 1'b0, 8'h06); cfg_write(3, 1'b1, 8'h07);
    cfg_write(6, 1'b0, 8'h05); cfg_write(6, 1'b1, 8'h55);
    // R7: register write itself touched no memory
    check_strobes("R7", 1'b0, 1'b0, 1'b0, 1'b0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].addr, VECS[i].rd, VECS[i].wr, 8'(i));
      check_strobes(VTAG[i], VECS[i].mcs, VECS[i].mwe, VECS[i].gcs, VECS[i].gwe);
      check(VTAG[i], "rd_sel", 32'(rd_sel), 32'(VECS[i].rsel));
      check("R5", "main_addr", 32'(main_addr), 32'(VECS[i].addr));
      if (VECS[i].gcs)
        check("R5", "gfx_addr", 32'(gfx_addr), 32'(VECS[i].gaddr));
    end

    // R6: read-back of mode and page through the register range
    access(16'hDE00, 1'b1, 1'b0, 8'h00);
    check("R6", "mode w0 readback", 32'(cfg_rdata), 32'h01);
    check("R6", "rd_sel on register read", 32'(rd_sel), 32'd2);
    check_strobes("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    access(16'hDE0D, 1'b1, 1'b0, 8'h00);
    check("R6", "page w6 readback", 32'(cfg_rdata), 32'h55);
    cfg_write(5, 1'b0, 8'hFF);
    access(16'hDE0A, 1'b1, 1'b0, 8'h00);
    check("R6", "mode upper bits read as zero", 32'(cfg_rdata), 32'h07);

    // R7: register range inside a graphics-mapped window stays registers
    access(16'hDE0F, 1'b1, 1'b0, 8'h00);
    check_strobes("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7", "page w7 readback", 32'(cfg_rdata), 32'h00);

    // R10: new mode and page used by the very next access
    cfg_write(4, 1'b0, 8'h01);
    access(16'h8000, 1'b1, 1'b0, 8'h00);
    check_strobes("R10", 1'b0, 1'b0, 1'b1, 1'b0);
    check("R10", "gfx_addr page 0", 32'(gfx_addr), 32'h000000);
    cfg_write(4, 1'b1, 8'h02);
    access(16'h8004, 1'b1, 1'b0, 8'h00);
    check("R10", "gfx_addr after page change", 32'(gfx_addr), 32'h004004);

    // R8: idle after activity
    idle();
    check_strobes("R8", 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule